// File: doc/BRIEF.md
# Register-Mapped Frame Buffer Network Interface

This peripheral sits between a host register bus and a pair of byte streams toward the line. It holds one receive frame and one transmit frame, each up to `FRAME_MAX` bytes (default 1514). The host moves a frame one byte per register access through a single data port for each direction. A small interrupt-control register carries the done flags, a self-test bit and a soft reset. A busy flag gates whether a new incoming frame may be taken.

On the line side, incoming bytes arrive with valid, start and end markers. The receive state machine has three states. `RX_IDLE` goes to `RX_FILL` when a start byte arrives while the block is ready. It goes to `RX_DROP` when a start byte arrives while the block is not ready. A start byte that is also an end byte is handled entirely inside `RX_IDLE`. `RX_FILL` and `RX_DROP` both return to `RX_IDLE` on the end byte.

A soft reset aborts an open frame: the state goes to `RX_DROP`, or to `RX_IDLE` if the end byte comes in that same cycle. The transmit state machine moves from `TX_IDLE` to `TX_SEND` when the host writes the last byte of a frame. It then puts out one byte per cycle and returns to `TX_IDLE` after the byte marked last. A new completion restarts `TX_SEND`, and a soft reset forces `TX_IDLE`.

Reads return data on `reg_rdata` one cycle after `reg_rd` is sampled. Any side effect of a read takes place at that same edge.

Top module: `nic_fbuf`

## Requirements
- R1: After reset the busy register (offset 0x08) reads 1, the receive count (0x0C), transmit count (0x10) and interrupt control (0x14) read 0, `irq` is 0 and `rx_ready` is 0.
- R2: The device ID is the ASCII string "FBUFNIC0", with the first character of each word in bits 7:0. Offset 0x00 reads 0x46554246 and offset 0x04 reads 0x3043494E. Offsets 0x18 and 0x20, non-word-aligned offsets and offsets 0x24 to 0x3C all read 0.
- R3: Writes to offsets 0x00, 0x08, 0x0C, 0x18 and 0x1C change nothing: busy and the receive count read back unchanged.
- R4: A write to 0x10 loads the transmit count with the write value if that value is at most 1514, and with 0 otherwise. The write also restarts the transmit byte pointer.
- R5: Each write to 0x20 stores `reg_wdata[7:0]` at the next position. When the number of stored bytes equals the transmit count, three things happen. The transmit count clears. Interrupt-control bit 0 (transmit done) sets. Busy becomes 1.
- R6: The cycle after a frame completes, `tx_valid` rises. The bytes follow in write order on consecutive cycles, and `tx_last` marks only the final byte.
- R7: A start byte is taken only while busy is 0 and the receive count is below 1514, which is also the condition that `rx_ready` shows. Taking a frame sets busy. At the end byte the receive count loads with the frame length and interrupt-control bit 1 (receive done) sets.
- R8: Each read of 0x1C with a nonzero receive count returns the next byte in arrival order and decrements the count. With a count of 0 it returns 0.
- R9: A frame that starts while the block is not ready is dropped whole. A frame longer than 1514 bytes keeps its first 1514 bytes and its count saturates at 1514.
- R10: Interrupt-control writes act by priority. Bit 0 set clears only transmit done. Otherwise bit 1 set clears only receive done. After any such write, busy equals 1 exactly when an interrupt-control bit remains set.
- R11: A write with bit 31 set and bits 1:0 clear is a soft reset. It clears both counts and both frames, sets test bit 31 and sets busy. The next read of 0x14 returns 0x80000000 and then clears bit 31. A following write of 0 drops busy to 0.
- R12: `irq` is 1 exactly while any interrupt-control bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register byte offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Incoming byte valid |
| rx_sof | input | 1 | Incoming byte is the first of a frame |
| rx_eof | input | 1 | Incoming byte is the last of a frame |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | A new frame would be taken |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |

## Verification
The transmit count is driven with a table of values below, at and above 1514, and with all ones, which separates the accept path from the zero-load path. The transmit frames are 5 bytes and 1 byte long, so the stream length and the position of the last marker are both checked at two sizes. The receive frames cover four cases: a short accepted frame, one that arrives while busy, one of 1520 bytes, and one that arrives while the count is saturated. Together these separate the busy gate from the count gate, and truncation from dropping. The interrupt-control writes combine bits 0, 1 and 31, so that each priority branch leaves a different readback.

// File: rtl/nic_fbuf_pkg.sv
`timescale 1ns/1ps
package nic_fbuf_pkg;
    localparam int REG_AW = 6;

    typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DROP} rx_state_e;
    typedef enum logic       {TX_IDLE, TX_SEND} tx_state_e;

    localparam logic [REG_AW-1:0] OFS_ID_LO = 6'h00;
    localparam logic [REG_AW-1:0] OFS_ID_HI = 6'h04;
    localparam logic [REG_AW-1:0] OFS_BUSY  = 6'h08;
    localparam logic [REG_AW-1:0] OFS_RXCNT = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_TXCNT = 6'h10;
    localparam logic [REG_AW-1:0] OFS_ICTL  = 6'h14;
    localparam logic [REG_AW-1:0] OFS_INFO  = 6'h18;
    localparam logic [REG_AW-1:0] OFS_RXDAT = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_TXDAT = 6'h20;

    // Word w of an 8-character ID; character 4w+j lands in byte j.
    function automatic logic [31:0] id_word(input logic [63:0] s, input int w);
        logic [31:0] r;
        r = '0;
        for (int j = 0; j < 4; j++) begin
            r[8*j +: 8] = s[63 - 8*(4*w + j) -: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/nic_fbuf_rx.sv
`timescale 1ns/1ps
module nic_fbuf_rx
    import nic_fbuf_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    localparam int CNT_W = $clog2(FRAME_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             busy,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             pop,
    output logic             rx_ready,
    output logic [CNT_W-1:0] count,
    output logic [7:0]       head_byte,
    output logic             take,
    output logic             done
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(FRAME_MAX);

    rx_state_e        state, state_n;
    logic [CNT_W-1:0] len, rd_ptr, wr_idx, len_n;
    logic [7:0]       mem [FRAME_MAX];
    logic             first_b, last_b, store;

    assign first_b = rx_valid && rx_sof;
    assign last_b  = rx_valid && rx_eof;

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE: if (first_b) state_n = rx_eof ? RX_IDLE : (rx_ready ? RX_FILL : RX_DROP);
            RX_FILL: if (last_b)  state_n = RX_IDLE;
            RX_DROP: if (last_b)  state_n = RX_IDLE;
            default: state_n = RX_IDLE;
        endcase
        if (soft_rst) state_n = (state != RX_IDLE && !last_b) ? RX_DROP : RX_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    // Outputs
    always_comb begin
        rx_ready  = (state == RX_IDLE) && !busy && (count < MAX_C);
        take      = (state == RX_IDLE) && first_b && rx_ready && !soft_rst;
        store     = take || ((state == RX_FILL) && rx_valid && !soft_rst);
        done      = !soft_rst && ((take && rx_eof) || ((state == RX_FILL) && last_b));
        wr_idx    = take ? '0 : len;
        len_n     = (wr_idx < MAX_C) ? wr_idx + CNT_W'(1) : wr_idx;
        head_byte = (rd_ptr < MAX_C) ? mem[rd_ptr] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (store && (wr_idx < MAX_C)) mem[wr_idx] <= rx_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            len    <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (store) len <= len_n;
            if (pop && (count != '0)) begin
                count  <= count - CNT_W'(1);
                rd_ptr <= rd_ptr + CNT_W'(1);
            end
            if (done) begin
                count  <= len_n;
                rd_ptr <= '0;
            end
        end
    end

    AST_RX_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count <= MAX_C); // R9
    AST_RX_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (count != '0) && !done && !soft_rst) |=> (count == $past(count) - CNT_W'(1))); // R8
    AST_RX_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (count != '0)); // R7
endmodule

// File: rtl/nic_fbuf_tx.sv
`timescale 1ns/1ps
module nic_fbuf_tx
    import nic_fbuf_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    localparam int CNT_W = $clog2(FRAME_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cnt_wr,
    input  logic             dat_wr,
    input  logic [31:0]      wval,
    output logic [CNT_W-1:0] count,
    output logic             sent,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(FRAME_MAX);

    tx_state_e        state, state_n;
    logic [CNT_W-1:0] wr_ptr, rd_ptr, send_len;
    logic [7:0]       mem [FRAME_MAX];
    logic             wr_ok, at_end;

    assign wr_ok  = dat_wr && (wr_ptr < MAX_C);
    assign sent   = wr_ok && !soft_rst && ((wr_ptr + CNT_W'(1)) == count);
    assign at_end = (rd_ptr + CNT_W'(1)) == send_len;

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            TX_IDLE: if (sent) state_n = TX_SEND;
            TX_SEND: if (!sent && at_end) state_n = TX_IDLE;
            default: state_n = TX_IDLE;
        endcase
        if (soft_rst) state_n = TX_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_n;
    end

    // Outputs
    always_comb begin
        tx_valid = (state == TX_SEND);
        tx_last  = (state == TX_SEND) && at_end;
        tx_data  = ((state == TX_SEND) && (rd_ptr < MAX_C)) ? mem[rd_ptr] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wval[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            count    <= '0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            send_len <= '0;
        end else begin
            if (state == TX_SEND) rd_ptr <= rd_ptr + CNT_W'(1);
            if (cnt_wr) begin
                count  <= (wval <= 32'(FRAME_MAX)) ? wval[CNT_W-1:0] : '0;
                wr_ptr <= '0;
            end
            if (wr_ok) begin
                if (sent) begin
                    count    <= '0;
                    wr_ptr   <= '0;
                    send_len <= count;
                    rd_ptr   <= '0;
                end else begin
                    wr_ptr <= wr_ptr + CNT_W'(1);
                end
            end
        end
    end

    AST_TX_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count <= MAX_C); // R4
    AST_TX_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sent |=> (count == '0)); // R5
    AST_TX_SEND_START: assert property (@(posedge clk) disable iff (!rst_n)
        sent |=> tx_valid); // R6
    AST_TX_STREAM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last && !soft_rst) |=> tx_valid); // R6
endmodule

// File: rtl/nic_fbuf.sv
`timescale 1ns/1ps
module nic_fbuf
    import nic_fbuf_pkg::*;
#(
    parameter int          FRAME_MAX = 1514,
    parameter logic [63:0] DEV_ID    = "FBUFNIC0",
    localparam int         CNT_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  reg_addr,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last
);
    localparam logic [31:0] ID_LO = id_word(DEV_ID, 0);
    localparam logic [31:0] ID_HI = id_word(DEV_ID, 1);

    logic             busy, busy_n;
    logic             ic_tx, ic_rx, ic_test, ic_tx_n, ic_rx_n, ic_test_n;
    logic             ictl_rd, ictl_wr, soft_rst, rx_pop, txc_wr, txd_wr;
    logic [CNT_W-1:0] rx_count, tx_count;
    logic [7:0]       rx_head;
    logic             rx_take, rx_done, tx_sent;
    logic [31:0]      ictl_word, rd_mux;

    assign ictl_rd  = reg_rd && (reg_addr == OFS_ICTL);
    assign ictl_wr  = reg_wr && (reg_addr == OFS_ICTL);
    assign soft_rst = ictl_wr && !reg_wdata[0] && !reg_wdata[1] && reg_wdata[31];
    assign rx_pop   = reg_rd && (reg_addr == OFS_RXDAT);
    assign txc_wr   = reg_wr && (reg_addr == OFS_TXCNT);
    assign txd_wr   = reg_wr && (reg_addr == OFS_TXDAT);
    assign ictl_word = {ic_test, 29'd0, ic_rx, ic_tx};
    assign irq       = ic_tx | ic_rx | ic_test;

    nic_fbuf_rx #(.FRAME_MAX(FRAME_MAX)) u_rx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .busy(busy),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .pop(rx_pop), .rx_ready(rx_ready), .count(rx_count), .head_byte(rx_head),
        .take(rx_take), .done(rx_done)
    );

    nic_fbuf_tx #(.FRAME_MAX(FRAME_MAX)) u_tx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cnt_wr(txc_wr),
        .dat_wr(txd_wr), .wval(reg_wdata), .count(tx_count), .sent(tx_sent),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    // Interrupt control and busy update; line events win over host acks.
    always_comb begin
        ic_tx_n   = ic_tx;
        ic_rx_n   = ic_rx;
        ic_test_n = ic_test;
        busy_n    = busy;
        if (ictl_rd) ic_test_n = 1'b0;
        if (ictl_wr) begin
            if (reg_wdata[0])       ic_tx_n = 1'b0;
            else if (reg_wdata[1])  ic_rx_n = 1'b0;
            else if (reg_wdata[31]) begin
                ic_tx_n   = 1'b0;
                ic_rx_n   = 1'b0;
                ic_test_n = 1'b1;
            end
            busy_n = ic_tx_n | ic_rx_n | ic_test_n;
        end
        if (tx_sent) begin
            ic_tx_n = 1'b1;
            busy_n  = 1'b1;
        end
        if (rx_take) busy_n  = 1'b1;
        if (rx_done) ic_rx_n = 1'b1;
    end

    always_comb begin
        case (reg_addr)
            OFS_ID_LO: rd_mux = ID_LO;
            OFS_ID_HI: rd_mux = ID_HI;
            OFS_BUSY:  rd_mux = {31'd0, busy};
            OFS_RXCNT: rd_mux = 32'(rx_count);
            OFS_TXCNT: rd_mux = 32'(tx_count);
            OFS_ICTL:  rd_mux = ictl_word;
            OFS_RXDAT: rd_mux = (rx_count != '0) ? {24'd0, rx_head} : 32'd0;
            default:   rd_mux = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b1;
            ic_tx     <= 1'b0;
            ic_rx     <= 1'b0;
            ic_test   <= 1'b0;
            reg_rdata <= 32'd0;
        end else begin
            busy    <= busy_n;
            ic_tx   <= ic_tx_n;
            ic_rx   <= ic_rx_n;
            ic_test <= ic_test_n;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    AST_SOFT_SETS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ic_test && busy && (rx_count == '0) && (tx_count == '0))); // R11
    AST_TAKE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |=> busy); // R7
    AST_SENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sent |=> (ic_tx && busy && irq)); // R5
    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> irq); // R12
    AST_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ictl_wr && !tx_sent && !rx_take && !rx_done) |=> (busy == (ic_tx | ic_rx | ic_test))); // R10
endmodule

// File: tb/nic_fbuf_tb.sv
`timescale 1ns/1ps
module nic_fbuf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, rx_ready, tx_valid, tx_last;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0, tx_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] cap [64];
    int cap_n = 0, last_at = -1;

    always #2.5 clk = ~clk;

    nic_fbuf u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    always @(negedge clk) begin
        if (tx_valid) begin
            if (cap_n < 64) cap[cap_n] = tx_data;
            if (tx_last) last_at = cap_n;
            cap_n++;
        end
    end

    // {write value, expected transmit count readback}
    localparam logic [63:0] TXC_VEC [6] = '{
        {32'd0,        32'd0},
        {32'd1,        32'd1},
        {32'd1514,     32'd1514},
        {32'd1515,     32'd0},
        {32'hFFFFFFFF, 32'd0},
        {32'd7,        32'd7}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        reg_read(a, v);
        chk(tag, v, exp);
    endtask

    task automatic send_rx(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1);
            rx_data = base + 8'(i);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 busy", 6'h08, 32'd1);
        rd_chk("R1 rxcnt", 6'h0C, 32'd0);
        rd_chk("R1 txcnt", 6'h10, 32'd0);
        rd_chk("R1 ictl", 6'h14, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 rx_ready", {31'd0, rx_ready}, 32'd0);

        // R2 ID and zero-reading offsets
        rd_chk("R2 id lo", 6'h00, 32'h46554246);
        rd_chk("R2 id hi", 6'h04, 32'h3043494E);
        rd_chk("R2 info", 6'h18, 32'd0);
        rd_chk("R2 txdat", 6'h20, 32'd0);
        rd_chk("R2 0x24", 6'h24, 32'd0);
        rd_chk("R2 0x3C", 6'h3C, 32'd0);
        rd_chk("R2 0x02", 6'h02, 32'd0);

        // R4 transmit count table
        foreach (TXC_VEC[k]) begin
            reg_write(6'h10, TXC_VEC[k][63:32]);
            rd_chk("R4 txcnt load", 6'h10, TXC_VEC[k][31:0]);
        end
        reg_write(6'h10, 32'd0);

        // R10/R11 ack write drops busy
        reg_write(6'h14, 32'd0);
        rd_chk("R11 busy after ack", 6'h08, 32'd0);

        // R3 writes to read-only registers
        reg_write(6'h08, 32'd1);
        reg_write(6'h0C, 32'd55);
        reg_write(6'h00, 32'hFFFF);
        reg_write(6'h18, 32'd9);
        reg_write(6'h1C, 32'd3);
        rd_chk("R3 busy unchanged", 6'h08, 32'd0);
        rd_chk("R3 rxcnt unchanged", 6'h0C, 32'd0);

        // R5/R6 five-byte transmit
        cap_n = 0; last_at = -1;
        reg_write(6'h10, 32'd5);
        reg_write(6'h20, 32'h1A0);
        reg_write(6'h20, 32'hA1);
        rd_chk("R5 txcnt held mid-frame", 6'h10, 32'd5);
        chk("R6 no stream mid-frame", cap_n, 0);
        reg_write(6'h20, 32'hA2);
        reg_write(6'h20, 32'hA3);
        reg_write(6'h20, 32'hA4);
        repeat (8) @(negedge clk);
        chk("R6 stream length", cap_n, 5);
        chk("R6 last position", last_at, 4);
        for (int i = 0; i < 5; i++) chk("R6 stream byte", {24'd0, cap[i]}, 32'hA0 + i);
        rd_chk("R5 txcnt cleared", 6'h10, 32'd0);
        rd_chk("R5 txdone set", 6'h14, 32'd1);
        rd_chk("R5 busy set", 6'h08, 32'd1);
        chk("R12 irq on txdone", {31'd0, irq}, 32'd1);

        // R10 bit1 with no rx done leaves tx done
        reg_write(6'h14, 32'd2);
        rd_chk("R10 bit1 keeps txdone", 6'h14, 32'd1);
        reg_write(6'h14, 32'd1);
        rd_chk("R10 txdone cleared", 6'h14, 32'd0);
        rd_chk("R10 busy follows", 6'h08, 32'd0);
        chk("R12 irq low", {31'd0, irq}, 32'd0);

        // R7/R8 receive
        chk("R7 ready when idle", {31'd0, rx_ready}, 32'd1);
        send_rx(4, 8'h30);
        rd_chk("R7 rxcnt", 6'h0C, 32'd4);
        rd_chk("R7 rxdone", 6'h14, 32'd2);
        chk("R7 not ready when busy", {31'd0, rx_ready}, 32'd0);
        chk("R12 irq on rxdone", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            rd_chk("R8 pop byte", 6'h1C, 32'h30 + i);
            rd_chk("R8 count step", 6'h0C, 32'(3 - i));
        end
        rd_chk("R8 empty pop", 6'h1C, 32'd0);

        // R9 frame while busy dropped
        send_rx(3, 8'h50);
        rd_chk("R9 busy drop count", 6'h0C, 32'd0);
        rd_chk("R9 busy drop data", 6'h1C, 32'd0);

        // R10 priority with both done bits set
        cap_n = 0; last_at = -1;
        reg_write(6'h10, 32'd1);
        reg_write(6'h20, 32'h77);
        repeat (4) @(negedge clk);
        chk("R6 one-byte frame", {24'd0, cap[0]}, 32'h77);
        chk("R6 one-byte last", last_at, 0);
        rd_chk("R10 both set", 6'h14, 32'd3);
        reg_write(6'h14, 32'd3);
        rd_chk("R10 bit0 first", 6'h14, 32'd2);
        rd_chk("R10 busy still", 6'h08, 32'd1);
        reg_write(6'h14, 32'h80000002);
        rd_chk("R10 bit1 over bit31", 6'h14, 32'd0);
        rd_chk("R10 busy cleared", 6'h08, 32'd0);

        // R9 truncation, R7 count gate
        send_rx(1520, 8'h00);
        rd_chk("R9 saturated count", 6'h0C, 32'd1514);
        reg_write(6'h14, 32'd2);
        rd_chk("R7 busy low", 6'h08, 32'd0);
        chk("R7 full blocks ready", {31'd0, rx_ready}, 32'd0);
        send_rx(2, 8'hEE);
        rd_chk("R9 full drop", 6'h0C, 32'd1514);
        rd_chk("R9 first byte kept", 6'h1C, 32'd0);
        rd_chk("R8 count after pop", 6'h0C, 32'd1513);
        chk("R7 ready below max", {31'd0, rx_ready}, 32'd1);

        // R11 soft reset
        reg_write(6'h10, 32'd7);
        reg_write(6'h14, 32'h80000000);
        chk("R11 irq on test", {31'd0, irq}, 32'd1);
        rd_chk("R11 busy", 6'h08, 32'd1);
        rd_chk("R11 rxcnt", 6'h0C, 32'd0);
        rd_chk("R11 txcnt", 6'h10, 32'd0);
        rd_chk("R11 ictl test", 6'h14, 32'h80000000);
        rd_chk("R11 test cleared", 6'h14, 32'd0);
        chk("R12 irq after clear", {31'd0, irq}, 32'd0);
        reg_write(6'h14, 32'd0);
        rd_chk("R11 busy after ack", 6'h08, 32'd0);
        chk("R11 ready again", {31'd0, rx_ready}, 32'd1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule